// File: doc/BRIEF.md
# UART Transmit/Receive FIFO Pair with Status

This block holds the two byte queues of a 16550-style serial port running in FIFO mode, together with the control and status logic around them. It contains no serializer, deserializer or baud-rate generator. The host side pushes bytes into the transmit queue, and the serializer drains them. The deserializer fills the receive queue, and the host drains it. A control write sets the FIFO enable and both trigger levels, and can flush either queue. A status word reports both occupancy counts, the two idle indications, and two sticky error flags that clear when the status word is read. A line-status word carries the empty and full indications.

All four data interfaces are valid/ready. A beat transfers on a rising clock edge when valid and ready are both high.

The host-write interface (`tx_wr_*`) is not stalled. A cycle in which valid is high and ready is low counts as a write to a full queue. The byte is dropped and the transmit-overrun flag is set.

The host-read interface (`rx_rd_*`) follows the same rule. A cycle in which ready is high and valid is low counts as a read of an empty queue. It returns zero, leaves the queue untouched and sets the receive-underrun flag.

On the serializer and deserializer sides, valid held against low ready simply waits.

When the enable bit is clear, each queue accepts only one entry, like a plain holding register.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset both counts are zero, both sticky flags are clear, the control read-back is 0x00, the status word is 0x00000003 with both shift registers idle, and the line-status word is 0x260.
- R2: Each queue delivers bytes in the order they were accepted, and each accepted push raises the count by one unless a pop or a flush happens in the same cycle.
- R3: With control bit 0 set, a queue holds up to DEPTH (32) entries. With it clear, a queue holds one entry. A count never exceeds DEPTH.
- R4: A host write while the transmit queue is full is dropped, the queued data is unchanged, and status bit 3 (transmit overrun) is set from the next cycle.
- R5: A host read of the empty receive queue returns 0x00, changes no count, and sets status bit 2 (receive underrun) from the next cycle.
- R6: Status bits 3 and 2 stay set until a cycle with `stat_rd` high. That cycle still shows them set, and they read zero from the next cycle, unless a new event of the same kind occurs in the read cycle, in which case the flag stays set.
- R7: A control write with bit 1 set empties the receive queue, and one with bit 2 set empties the transmit queue, from the next cycle. A flush wins over a push in the same cycle. The other queue is untouched, and `ctl_rdata` always reads bits 2:1 as zero.
- R8: Receive trigger field, control bits 7:6: codes 0, 1, 2, 3 raise `rx_trig_hit` when the receive count exceeds 1, 4, 8, 16 respectively.
- R9: Transmit trigger field, control bits 5:4: codes 0, 1, 2, 3 raise `tx_trig_hit` when the transmit count exceeds 16, 8, 4, 1 respectively.
- R10: Status word bits 29:24 hold the transmit count and bits 21:16 hold the receive count. All other bits not named in R6 or R11 read zero.
- R11: Status bit 0 (transmit idle) is high when the transmit count is zero and `tx_shift_busy` is low. Bit 1 (receive idle) is the same for the receive count and `rx_shift_busy`.
- R12: Line-status bits:
  - bit 9 is high when the receive queue is empty;
  - bit 8 is high when the transmit queue is full;
  - bit 6 is high when the transmit queue is empty and `tx_shift_busy` is low;
  - bit 5 is high when the transmit queue has room;
  - bit 0 is high when receive data is waiting;
  - all other bits are zero.
- R13: Every ready output equals "queue not full", every valid output equals "queue not empty", and data outputs read 0x00 while their queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control data: bit 0 enable, bit 1 receive flush, bit 2 transmit flush, 5:4 transmit trigger, 7:6 receive trigger |
| ctl_rdata | output | 8 | Control read-back, flush bits always zero |
| tx_wr_valid | input | 1 | Host write valid |
| tx_wr_ready | output | 1 | Transmit queue has room |
| tx_wr_data | input | 8 | Host write byte |
| tx_out_valid | output | 1 | Byte available to serializer |
| tx_out_ready | input | 1 | Serializer takes byte |
| tx_out_data | output | 8 | Byte to serializer |
| tx_shift_busy | input | 1 | Serializer shift register busy |
| rx_in_valid | input | 1 | Deserializer byte valid |
| rx_in_ready | output | 1 | Receive queue has room |
| rx_in_data | input | 8 | Deserializer byte |
| rx_rd_valid | output | 1 | Received byte waiting |
| rx_rd_ready | input | 1 | Host read strobe |
| rx_rd_data | output | 8 | Byte to host, zero when empty |
| rx_shift_busy | input | 1 | Deserializer shift register busy |
| stat_rd | input | 1 | Status read strobe, clears sticky flags |
| stat_word | output | 32 | Status word (counts, sticky flags, idle) |
| line_stat | output | 10 | Line-status word |
| rx_trig_hit | output | 1 | Receive count above its trigger level |
| tx_trig_hit | output | 1 | Transmit count above its trigger level |

## Verification
The bound checker checks the following properties on every cycle:
- the count bound;
- the setting of overrun and underrun one cycle after a refused transfer;
- the holding of sticky flags without a read, and their clearing after a read;
- the emptying of a queue after a flush write and the zero read-back of the flush bits;
- the zero data of an empty receive queue;
- the one-step growth of a count on a lone push;
- the consistency of transmit idle with count and shift state.

Only the bench scenarios can show:
- first-in first-out ordering across a full wrap of 32 entries;
- the exact trigger thresholds of each code in both directions;
- the one-entry capacity with the enable bit clear;
- that a flush leaves the other queue intact;
- that a status read coinciding with a new event keeps the flag.

// File: rtl/ufp_pkg.sv
package ufp_pkg;

  localparam int STAT_CNT_W = 6;

  // Receive trigger thresholds: ascending with code.
  function automatic logic [4:0] rx_level(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  // Transmit trigger thresholds: descending with code.
  function automatic logic [4:0] tx_level(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd16;
      2'd1:    return 5'd8;
      2'd2:    return 5'd4;
      default: return 5'd1;
    endcase
  endfunction

  typedef struct packed {
    logic       en;
    logic [1:0] rx_code;
    logic [1:0] tx_code;
  } ufp_cfg_t;

endpackage

// File: rtl/ufp_fifo.sv
module ufp_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          one_deep,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  output logic          push_ready,
  output logic          pop_valid,
  input  logic          pop_ready,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cap;
  logic          do_push, do_pop;

  assign cap        = one_deep ? CW'(1) : CW'(DEPTH);
  assign push_ready = (count < cap);
  assign pop_valid  = (count != '0);
  assign pop_data   = pop_valid ? mem[rd_ptr] : '0;
  assign do_push    = push_valid && push_ready && !flush;
  assign do_pop     = pop_ready && pop_valid && !flush;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/ufp_ctl.sv
module ufp_ctl
  import ufp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output ufp_cfg_t   cfg,
  output logic       rx_flush,
  output logic       tx_flush,
  output logic [7:0] ctl_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (ctl_wr) begin
      cfg.en      <= ctl_wdata[0];
      cfg.tx_code <= ctl_wdata[5:4];
      cfg.rx_code <= ctl_wdata[7:6];
    end
  end

  // Flush bits act as one-cycle pulses and are never stored.
  assign rx_flush  = ctl_wr && ctl_wdata[1];
  assign tx_flush  = ctl_wr && ctl_wdata[2];
  assign ctl_rdata = {cfg.rx_code, cfg.tx_code, 3'b000, cfg.en};

endmodule

// File: rtl/ufp_sticky.sv
module ufp_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_clr,
  input  logic evt,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (evt)    flag <= 1'b1;
    else if (rd_clr) flag <= 1'b0;
  end

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
  import ufp_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_rdata,
  input  logic          tx_wr_valid,
  output logic          tx_wr_ready,
  input  logic [DW-1:0] tx_wr_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [DW-1:0] tx_out_data,
  input  logic          tx_shift_busy,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [DW-1:0] rx_in_data,
  output logic          rx_rd_valid,
  input  logic          rx_rd_ready,
  output logic [DW-1:0] rx_rd_data,
  input  logic          rx_shift_busy,
  input  logic          stat_rd,
  output logic [31:0]   stat_word,
  output logic [9:0]    line_stat,
  output logic          rx_trig_hit,
  output logic          tx_trig_hit
);

  localparam int CW = $clog2(DEPTH + 1);

  ufp_cfg_t      cfg;
  logic          rx_flush, tx_flush;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          ovr_flag, und_flag;
  logic          tx_idle, rx_idle, tx_all_empty;
  logic [STAT_CNT_W-1:0] tx_cnt_f, rx_cnt_f;

  ufp_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .cfg       (cfg),
    .rx_flush  (rx_flush),
    .tx_flush  (tx_flush),
    .ctl_rdata (ctl_rdata)
  );

  ufp_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (tx_flush),
    .one_deep   (!cfg.en),
    .push_valid (tx_wr_valid),
    .push_data  (tx_wr_data),
    .push_ready (tx_wr_ready),
    .pop_valid  (tx_out_valid),
    .pop_ready  (tx_out_ready),
    .pop_data   (tx_out_data),
    .count      (tx_cnt)
  );

  ufp_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (rx_flush),
    .one_deep   (!cfg.en),
    .push_valid (rx_in_valid),
    .push_data  (rx_in_data),
    .push_ready (rx_in_ready),
    .pop_valid  (rx_rd_valid),
    .pop_ready  (rx_rd_ready),
    .pop_data   (rx_rd_data),
    .count      (rx_cnt)
  );

  ufp_sticky u_ovr (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_clr (stat_rd),
    .evt    (tx_wr_valid && !tx_wr_ready),
    .flag   (ovr_flag)
  );

  ufp_sticky u_und (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_clr (stat_rd),
    .evt    (rx_rd_ready && !rx_rd_valid),
    .flag   (und_flag)
  );

  assign tx_cnt_f     = STAT_CNT_W'(tx_cnt);
  assign rx_cnt_f     = STAT_CNT_W'(rx_cnt);
  assign tx_all_empty = !tx_out_valid && !tx_shift_busy;
  assign tx_idle      = tx_all_empty;
  assign rx_idle      = !rx_rd_valid && !rx_shift_busy;

  assign stat_word = {2'b00, tx_cnt_f, 2'b00, rx_cnt_f, 12'h000,
                      ovr_flag, und_flag, rx_idle, tx_idle};

  assign line_stat = {!rx_rd_valid, !tx_wr_ready, 1'b0, tx_all_empty,
                      tx_wr_ready, 4'b0000, rx_rd_valid};

  assign rx_trig_hit = (rx_cnt > CW'(rx_level(cfg.rx_code)));
  assign tx_trig_hit = (tx_cnt > CW'(tx_level(cfg.tx_code)));

endmodule

// File: rtl/ufp_checker.sv
module ufp_checker #(
  parameter int DEPTH = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr,
  input logic [7:0]  ctl_wdata,
  input logic [7:0]  ctl_rdata,
  input logic        tx_wr_valid,
  input logic        tx_wr_ready,
  input logic        tx_shift_busy,
  input logic        rx_in_valid,
  input logic        rx_in_ready,
  input logic        rx_rd_valid,
  input logic        rx_rd_ready,
  input logic [7:0]  rx_rd_data,
  input logic        stat_rd,
  input logic [31:0] stat_word
);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[29:24] <= 6'(DEPTH)) && (stat_word[21:16] <= 6'(DEPTH)));

  p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr_valid && !tx_wr_ready |=> stat_word[3]);

  p_und_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd_ready && !rx_rd_valid |=> stat_word[2]);

  p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[3] && !stat_rd |=> stat_word[3]);

  p_rd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !(rx_rd_ready && !rx_rd_valid) |=> !stat_word[2]);

  p_tx_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_wdata[2] |=> stat_word[29:24] == 6'd0);

  p_flush_rdbk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[2:1] == 2'b00);

  p_rx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_in_valid && rx_in_ready && !(ctl_wr && ctl_wdata[1])
      && !(rx_rd_ready && rx_rd_valid)
    |=> stat_word[21:16] == $past(stat_word[21:16]) + 6'd1);

  p_empty_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_rd_valid |-> rx_rd_data == 8'h00);

  p_tx_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[0] |-> (stat_word[29:24] == 6'd0) && !tx_shift_busy);

endmodule

bind uart_fifo_pair ufp_checker #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctl_wr        (ctl_wr),
  .ctl_wdata     (ctl_wdata),
  .ctl_rdata     (ctl_rdata),
  .tx_wr_valid   (tx_wr_valid),
  .tx_wr_ready   (tx_wr_ready),
  .tx_shift_busy (tx_shift_busy),
  .rx_in_valid   (rx_in_valid),
  .rx_in_ready   (rx_in_ready),
  .rx_rd_valid   (rx_rd_valid),
  .rx_rd_ready   (rx_rd_ready),
  .rx_rd_data    (rx_rd_data),
  .stat_rd       (stat_rd),
  .stat_word     (stat_word)
);

// File: tb/uart_fifo_pair_bench.sv
module uart_fifo_pair_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_rdata;
  logic        tx_wr_valid = 1'b0;
  logic        tx_wr_ready;
  logic [7:0]  tx_wr_data = '0;
  logic        tx_out_valid;
  logic        tx_out_ready = 1'b0;
  logic [7:0]  tx_out_data;
  logic        tx_shift_busy = 1'b0;
  logic        rx_in_valid = 1'b0;
  logic        rx_in_ready;
  logic [7:0]  rx_in_data = '0;
  logic        rx_rd_valid;
  logic        rx_rd_ready = 1'b0;
  logic [7:0]  rx_rd_data;
  logic        rx_shift_busy = 1'b0;
  logic        stat_rd = 1'b0;
  logic [31:0] stat_word;
  logic [9:0]  line_stat;
  logic        rx_trig_hit, tx_trig_hit;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_fifo_pair u_uart_fifo_pair (.*);

  typedef struct packed {
    logic       is_rx;
    logic [1:0] code;
    logic [4:0] thr;
  } trig_vec_t;

  localparam trig_vec_t TRIG_TBL [8] = '{
    '{1'b1, 2'd0, 5'd1},  '{1'b1, 2'd1, 5'd4},
    '{1'b1, 2'd2, 5'd8},  '{1'b1, 2'd3, 5'd16},
    '{1'b0, 2'd0, 5'd16}, '{1'b0, 2'd1, 5'd8},
    '{1'b0, 2'd2, 5'd4},  '{1'b0, 2'd3, 5'd1}
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [7:0] w);
    ctl_wr = 1'b1; ctl_wdata = w;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] d);
    tx_wr_valid = 1'b1; tx_wr_data = d;
    @(negedge clk);
    tx_wr_valid = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] d);
    rx_in_valid = 1'b1; rx_in_data = d;
    @(negedge clk);
    rx_in_valid = 1'b0;
  endtask

  task automatic pop_tx(output logic [7:0] d);
    d = tx_out_data; tx_out_ready = 1'b1;
    @(negedge clk);
    tx_out_ready = 1'b0;
  endtask

  task automatic pop_rx(output logic [7:0] d);
    d = rx_rd_data; rx_rd_ready = 1'b1;
    @(negedge clk);
    rx_rd_ready = 1'b0;
  endtask

  task automatic stat_read(output logic [31:0] w);
    w = stat_word; stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 stat", stat_word, 32'h0000_0003);
    check("R1 ctl", {24'h0, ctl_rdata}, 32'h0);
    check("R1 line", {22'h0, line_stat}, 32'h260);

    // R3: enable clear -> one entry; R4 overrun on second write
    push_tx(8'hA1);
    check("R3 one-deep full", {31'h0, tx_wr_ready}, 32'h0);
    push_tx(8'hB2);
    check("R4 count", {26'h0, stat_word[29:24]}, 32'd1);
    check("R4 ovr set", {31'h0, stat_word[3]}, 32'h1);
    check("R12 tx full", {31'h0, line_stat[8]}, 32'h1);
    // R6: read with a new overrun in the same cycle keeps flag
    tx_wr_valid = 1'b1; tx_wr_data = 8'hC3;
    stat_read(w);
    tx_wr_valid = 1'b0;
    check("R6 read shows set", {31'h0, w[3]}, 32'h1);
    check("R6 same-cycle event keeps", {31'h0, stat_word[3]}, 32'h1);
    stat_read(w);
    check("R6 cleared after read", {31'h0, stat_word[3]}, 32'h0);
    pop_tx(d);
    check("R4 data kept", {24'h0, d}, 32'hA1);

    // R2/R3: full 32-entry transmit queue, in order
    ctl_write(8'h01);
    for (int i = 0; i < 32; i++) push_tx(8'(i * 7 + 3));
    check("R3 tx count 32", {26'h0, stat_word[29:24]}, 32'd32);
    check("R13 tx ready low", {31'h0, tx_wr_ready}, 32'h0);
    push_tx(8'hEE);
    check("R4 ovr full32", {31'h0, stat_word[3]}, 32'h1);
    begin
      int bad = 0;
      for (int i = 0; i < 32; i++) begin
        pop_tx(d);
        if (d !== 8'(i * 7 + 3)) bad++;
      end
      check("R2 tx order", bad, 0);
    end
    check("R13 tx empty valid", {31'h0, tx_out_valid}, 32'h0);
    check("R13 tx empty data", {24'h0, tx_out_data}, 32'h0);
    stat_read(w);

    // R10/R2/R5: receive path
    push_rx(8'h11); push_rx(8'h22); push_rx(8'h33);
    check("R10 rx count field", stat_word, 32'h0003_0001);
    check("R12 rx ready bit", {22'h0, line_stat}, 32'h061);
    pop_rx(d); check("R2 rx first", {24'h0, d}, 32'h11);
    pop_rx(d); check("R2 rx second", {24'h0, d}, 32'h22);
    pop_rx(d); check("R2 rx third", {24'h0, d}, 32'h33);
    pop_rx(d);
    check("R5 empty read zero", {24'h0, d}, 32'h0);
    check("R5 und set", stat_word, 32'h0000_0007);
    stat_read(w);
    check("R6 und cleared", {31'h0, stat_word[2]}, 32'h0);

    // R7: flushes
    for (int i = 0; i < 5; i++) push_tx(8'(i));
    for (int i = 0; i < 4; i++) push_rx(8'(i + 8'h40));
    ctl_write(8'h05);
    check("R7 tx flushed", {26'h0, stat_word[29:24]}, 32'd0);
    check("R7 rx untouched", {26'h0, stat_word[21:16]}, 32'd4);
    check("R7 readback", {24'h0, ctl_rdata}, 32'h01);
    rx_in_valid = 1'b1; rx_in_data = 8'h99;
    ctl_write(8'h03);
    rx_in_valid = 1'b0;
    check("R7 rx flush wins", {26'h0, stat_word[21:16]}, 32'd0);

    // R11/R12: shift busy affects idle
    tx_shift_busy = 1'b1; rx_shift_busy = 1'b1;
    @(negedge clk);
    check("R11 busy not idle", {30'h0, stat_word[1:0]}, 32'h0);
    check("R12 tx not all empty", {31'h0, line_stat[6]}, 32'h0);
    tx_shift_busy = 1'b0; rx_shift_busy = 1'b0;

    // R8/R9: trigger table
    for (int k = 0; k < 8; k++) begin
      trig_vec_t v = TRIG_TBL[k];
      logic hit;
      if (v.is_rx) ctl_write({v.code, 2'b00, 4'b0111});
      else         ctl_write({2'b00, v.code, 4'b0111});
      for (int n = 0; n < int'(v.thr); n++) begin
        if (v.is_rx) push_rx(8'(n)); else push_tx(8'(n));
      end
      hit = v.is_rx ? rx_trig_hit : tx_trig_hit;
      check(v.is_rx ? "R8 at level" : "R9 at level", {31'h0, hit}, 32'h0);
      if (v.is_rx) push_rx(8'hFF); else push_tx(8'hFF);
      hit = v.is_rx ? rx_trig_hit : tx_trig_hit;
      check(v.is_rx ? "R8 above level" : "R9 above level", {31'h0, hit}, 32'h1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule